// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens a 12-bit word-addressed processor to a 15-bit address space. It holds a 3-bit instruction field (IF), a 3-bit data field (DF), a 3-bit instruction buffer (IB) and a 6-bit save register (SF). The processor core presents every decoded I/O instruction to the block together with the instruction word. The block carries out the field-control group: it loads fields, reads them back to the accumulator and restores saved state. It prefixes 12-bit addresses with the proper field to form 15-bit fetch and operand addresses.

A new instruction field is not applied at once. It sits in the buffer until the core reports a completed jump or subroutine call. Until then the block raises an inhibit that the core uses to hold off interrupts. On interrupt entry the block saves the current IF and DF into SF and drops both to field zero, so the service routine runs in field zero. A later restore instruction plus a jump brings the interrupted program's fields back.

Top module: `memfield_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, IF, DF, IB and SF read zero, `xfer_pending` and `int_inhibit` are low and `ac_valid` is low.
- R2: A field-control word (instruction bits [11:9]=110, bits [8:6]=010) with function bits [2:0]=001 loads DF from bits [5:3] at the next clock edge; IF and IB do not change.
- R3: Function 010 loads IB from bits [5:3] and sets `xfer_pending` and `int_inhibit`; IF keeps its old value until a transfer completes.
- R4: `xfer_strobe` while a transfer is pending copies IB into IF and clears `xfer_pending` and `int_inhibit`; `xfer_strobe` with nothing pending changes nothing.
- R5: `int_entry` while `int_inhibit` is low stores {IF, DF} into SF (IF in bits [5:3]) and clears IF and DF; while `int_inhibit` is high it is ignored.
- R6: Function 100 with bits [5:3]=001 makes `ac_valid` high one cycle later with `ac_data` = DF in bits [5:3] and zero elsewhere.
- R7: Function 100 with bits [5:3]=010 returns IF in `ac_data` bits [5:3], zero elsewhere, one cycle later.
- R8: Function 100 with bits [5:3]=011 returns SF in `ac_data` bits [5:0], zero elsewhere, one cycle later.
- R9: Function 100 with bits [5:3]=100 loads IB from SF[5:3] and DF from SF[2:0], and sets `xfer_pending` and `int_inhibit`.
- R10: `fetch_addr` is {IF, `pc_addr`}; `oper_addr` is {DF, `ptr_addr`} when `ptr_indirect` is high and {IF, `ptr_addr`} otherwise, with no clock delay.
- R11: Words with another opcode, another device select, or an unlisted function or sub-code change no field and never raise `ac_valid`.
- R12: When events meet in one cycle, an accepted interrupt entry wins over a pending transfer, which wins over the I/O instruction; the losing I/O instruction is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iot_strobe | input | 1 | One-cycle pulse: `instr` holds an I/O instruction to execute |
| instr | input | 12 | Instruction word |
| xfer_strobe | input | 1 | One-cycle pulse: a jump or subroutine call completed |
| int_entry | input | 1 | One-cycle pulse: the core is entering an interrupt |
| pc_addr | input | 12 | 12-bit program counter for fetch |
| ptr_addr | input | 12 | 12-bit operand address |
| ptr_indirect | input | 1 | Operand address came through an indirect pointer |
| if_field | output | 3 | Current instruction field |
| df_field | output | 3 | Current data field |
| ib_field | output | 3 | Instruction buffer |
| save_field | output | 6 | Saved {IF, DF} |
| xfer_pending | output | 1 | Field change waits for a jump |
| int_inhibit | output | 1 | Interrupt recognition must be held off |
| fetch_addr | output | 15 | Extended fetch address |
| oper_addr | output | 15 | Extended operand address |
| ac_valid | output | 1 | `ac_data` carries a readback this cycle |
| ac_data | output | 12 | Value for the accumulator |

## Verification
The hardest situations are the same-cycle collisions of R12 and an interrupt arriving while a field change is pending, because a well-behaved core never produces them. The bench drives the strobes directly, so it first parks the block in the pending state with a change instruction, fires `int_entry` there, and later fires an interrupt together with a data-field load and a transfer together with another load. Each readback is queued in the bench when its instruction is issued and compared when `ac_valid` appears, so an unexpected or missing readback is caught.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD_DF,
    OP_LOAD_IB,
    OP_READ_DF,
    OP_READ_IF,
    OP_READ_SF,
    OP_RESTORE
  } mf_op_e;
endpackage

// File: rtl/mf_decode.sv
module mf_decode
  import mf_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3
) (
  input  logic               iot_strobe,
  input  logic [WORD_W-1:0]  instr,
  output mf_op_e             op,
  output logic [FIELD_W-1:0] fld_num
);
  localparam logic [2:0] OPC_IOT  = 3'b110;
  localparam logic [2:0] DEV_HIGH = 3'b010;

  logic grp_hit;

  assign grp_hit = iot_strobe
                 && (instr[WORD_W-1 -: 3] == OPC_IOT)
                 && (instr[8:6] == DEV_HIGH);
  assign fld_num = instr[FIELD_W+2:3];

  always_comb begin
    op = OP_NONE;
    if (grp_hit) begin
      case (instr[2:0])
        3'b001: op = OP_LOAD_DF;
        3'b010: op = OP_LOAD_IB;
        3'b100: begin
          case (instr[5:3])
            3'b001:  op = OP_READ_DF;
            3'b010:  op = OP_READ_IF;
            3'b011:  op = OP_READ_SF;
            3'b100:  op = OP_RESTORE;
            default: op = OP_NONE;
          endcase
        end
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mf_state.sv
module mf_state
  import mf_pkg::*;
#(
  parameter int FIELD_W = 3,
  localparam int SAVE_W = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  mf_op_e             op,
  input  logic [FIELD_W-1:0] fld_num,
  input  logic               xfer_strobe,
  input  logic               int_entry,
  output logic [FIELD_W-1:0] if_q,
  output logic [FIELD_W-1:0] df_q,
  output logic [FIELD_W-1:0] ib_q,
  output logic [SAVE_W-1:0]  sf_q,
  output logic               pend_q,
  output logic               inh_q,
  output logic               iot_go
);
  logic int_go, xfer_go;

  assign int_go  = int_entry && !inh_q;
  assign xfer_go = xfer_strobe && pend_q;
  assign iot_go  = !int_go && !xfer_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      if_q   <= '0;
      df_q   <= '0;
      ib_q   <= '0;
      sf_q   <= '0;
      pend_q <= 1'b0;
      inh_q  <= 1'b0;
    end else if (int_go) begin
      sf_q <= {if_q, df_q};
      if_q <= '0;
      df_q <= '0;
    end else if (xfer_go) begin
      if_q   <= ib_q;
      pend_q <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      case (op)
        OP_LOAD_DF: df_q <= fld_num;
        OP_LOAD_IB: begin
          ib_q   <= fld_num;
          pend_q <= 1'b1;
          inh_q  <= 1'b1;
        end
        OP_RESTORE: begin
          ib_q   <= sf_q[SAVE_W-1:FIELD_W];
          df_q   <= sf_q[FIELD_W-1:0];
          pend_q <= 1'b1;
          inh_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_DF_LOAD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD_DF && iot_go) |=> (df_q == $past(fld_num))); // R2
  AST_IF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!xfer_go && !int_go) |=> $stable(if_q)); // R3
  AST_XFER_DONE: assert property (@(posedge clk) disable iff (rst)
    xfer_go |=> (!pend_q && !inh_q && if_q == $past(ib_q))); // R4
  AST_INT_SAVE: assert property (@(posedge clk) disable iff (rst)
    int_go |=> (if_q == '0 && df_q == '0 && sf_q == $past({if_q, df_q}))); // R5
  AST_INT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (int_entry && inh_q) |=> $stable(sf_q)); // R5
endmodule

// File: rtl/mf_readback.sv
module mf_readback
  import mf_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3,
  localparam int SAVE_W = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  mf_op_e             op,
  input  logic               allow,
  input  logic [FIELD_W-1:0] if_q,
  input  logic [FIELD_W-1:0] df_q,
  input  logic [SAVE_W-1:0]  sf_q,
  output logic               ac_valid,
  output logic [WORD_W-1:0]  ac_data
);
  logic [WORD_W-1:0] rd_val;
  logic              rd_hit;

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    case (op)
      OP_READ_DF: begin rd_val[SAVE_W-1:FIELD_W] = df_q; rd_hit = 1'b1; end
      OP_READ_IF: begin rd_val[SAVE_W-1:FIELD_W] = if_q; rd_hit = 1'b1; end
      OP_READ_SF: begin rd_val[SAVE_W-1:0]       = sf_q; rd_hit = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_valid <= 1'b0;
      ac_data  <= '0;
    end else begin
      ac_valid <= rd_hit && allow;
      ac_data  <= (rd_hit && allow) ? rd_val : '0;
    end
  end

  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    ac_valid |-> (ac_data[WORD_W-1:SAVE_W] == '0)); // R6
  AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE) |=> !ac_valid); // R11
endmodule

// File: rtl/mf_merge.sv
module mf_merge #(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3,
  localparam int ADDR_W = WORD_W + FIELD_W
) (
  input  logic [FIELD_W-1:0] if_q,
  input  logic [FIELD_W-1:0] df_q,
  input  logic [WORD_W-1:0]  pc_addr,
  input  logic [WORD_W-1:0]  ptr_addr,
  input  logic               ptr_indirect,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  oper_addr
);
  assign fetch_addr = {if_q, pc_addr};
  assign oper_addr  = {(ptr_indirect ? df_q : if_q), ptr_addr};
endmodule

// File: rtl/memfield_ctrl.sv
module memfield_ctrl
  import mf_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3,
  localparam int ADDR_W = WORD_W + FIELD_W,
  localparam int SAVE_W = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iot_strobe,
  input  logic [WORD_W-1:0]  instr,
  input  logic               xfer_strobe,
  input  logic               int_entry,
  input  logic [WORD_W-1:0]  pc_addr,
  input  logic [WORD_W-1:0]  ptr_addr,
  input  logic               ptr_indirect,
  output logic [FIELD_W-1:0] if_field,
  output logic [FIELD_W-1:0] df_field,
  output logic [FIELD_W-1:0] ib_field,
  output logic [SAVE_W-1:0]  save_field,
  output logic               xfer_pending,
  output logic               int_inhibit,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  oper_addr,
  output logic               ac_valid,
  output logic [WORD_W-1:0]  ac_data
);
  mf_op_e             op;
  logic [FIELD_W-1:0] fld_num;
  logic               iot_go;

  mf_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_dec (
    .iot_strobe(iot_strobe), .instr(instr), .op(op), .fld_num(fld_num)
  );

  mf_state #(.FIELD_W(FIELD_W)) u_st (
    .clk(clk), .rst(rst), .op(op), .fld_num(fld_num),
    .xfer_strobe(xfer_strobe), .int_entry(int_entry),
    .if_q(if_field), .df_q(df_field), .ib_q(ib_field), .sf_q(save_field),
    .pend_q(xfer_pending), .inh_q(int_inhibit), .iot_go(iot_go)
  );

  mf_readback #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_rb (
    .clk(clk), .rst(rst), .op(op), .allow(iot_go),
    .if_q(if_field), .df_q(df_field), .sf_q(save_field),
    .ac_valid(ac_valid), .ac_data(ac_data)
  );

  mf_merge #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_mg (
    .if_q(if_field), .df_q(df_field), .pc_addr(pc_addr),
    .ptr_addr(ptr_addr), .ptr_indirect(ptr_indirect),
    .fetch_addr(fetch_addr), .oper_addr(oper_addr)
  );
endmodule

// File: tb/sim_memfield_ctrl.sv
module sim_memfield_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iot_strobe = 1'b0;
  logic [11:0] instr = '0;
  logic        xfer_strobe = 1'b0;
  logic        int_entry = 1'b0;
  logic [11:0] pc_addr = '0;
  logic [11:0] ptr_addr = '0;
  logic        ptr_indirect = 1'b0;
  logic [2:0]  if_field, df_field, ib_field;
  logic [5:0]  save_field;
  logic        xfer_pending, int_inhibit, ac_valid;
  logic [14:0] fetch_addr, oper_addr;
  logic [11:0] ac_data;

  int total = 0;
  int bad = 0;
  logic [11:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  memfield_ctrl u0 (
    .clk(clk), .rst(rst), .iot_strobe(iot_strobe), .instr(instr),
    .xfer_strobe(xfer_strobe), .int_entry(int_entry),
    .pc_addr(pc_addr), .ptr_addr(ptr_addr), .ptr_indirect(ptr_indirect),
    .if_field(if_field), .df_field(df_field), .ib_field(ib_field),
    .save_field(save_field), .xfer_pending(xfer_pending),
    .int_inhibit(int_inhibit), .fetch_addr(fetch_addr),
    .oper_addr(oper_addr), .ac_valid(ac_valid), .ac_data(ac_data)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0o expected %0o", req, got, exp);
    end
  endtask

  // monitor: every readback must match the oldest queued expectation
  always @(negedge clk) begin
    if (!rst && ac_valid) begin
      if (exp_q.size() == 0) chk("R11 stray readback", 32'(ac_data), 32'hFFFF);
      else chk("R6/R7/R8 readback", 32'(ac_data), 32'(exp_q.pop_front()));
    end
  end

  // driver: present one cycle of stimulus starting at a falling edge
  task automatic step(logic iot, logic [11:0] w, logic xf, logic ie);
    iot_strobe  = iot;
    instr       = w;
    xfer_strobe = xf;
    int_entry   = ie;
    @(posedge clk);
    @(negedge clk);
    iot_strobe  = 1'b0;
    xfer_strobe = 1'b0;
    int_entry   = 1'b0;
  endtask

  task automatic fields(string req, logic [2:0] ei, logic [2:0] ed,
                        logic [2:0] eb, logic [5:0] es, logic ep);
    chk({req, " IF"}, 32'(if_field), 32'(ei));
    chk({req, " DF"}, 32'(df_field), 32'(ed));
    chk({req, " IB"}, 32'(ib_field), 32'(eb));
    chk({req, " SF"}, 32'(save_field), 32'(es));
    chk({req, " pending"}, 32'(xfer_pending), 32'(ep));
    chk({req, " inhibit"}, 32'(int_inhibit), 32'(ep));
  endtask

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    fields("R1 in reset", 0, 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    fields("R1 after reset", 0, 0, 0, 0, 0);
    chk("R1 ac_valid", 32'(ac_valid), 0);

    step(1, 12'o6231, 0, 0);                 // R2 load DF=3
    fields("R2", 0, 3, 0, 0, 0);

    exp_q.push_back(12'o0030);               // R6 read DF
    step(1, 12'o6214, 0, 0);
    chk("R6 valid", 32'(ac_valid), 1);

    step(1, 12'o6252, 0, 0);                 // R3 IB=5 pending
    fields("R3", 0, 3, 5, 0, 1);
    pc_addr = 12'o1234; ptr_addr = 12'o0777; ptr_indirect = 1'b0;
    #1 chk("R10 fetch IF0", 32'(fetch_addr), 32'(15'o01234));
    chk("R10 direct IF0", 32'(oper_addr), 32'(15'o00777));

    step(0, 12'o0000, 0, 1);                 // R5 ignored while inhibited
    fields("R5 inhibited", 0, 3, 5, 0, 1);

    step(0, 12'o0000, 1, 0);                 // R4 transfer
    fields("R4 transfer", 5, 3, 5, 0, 0);
    chk("R10 fetch IF5", 32'(fetch_addr), 32'(15'o51234));
    chk("R10 direct IF5", 32'(oper_addr), 32'(15'o50777));
    ptr_indirect = 1'b1;
    #1 chk("R10 indirect DF3", 32'(oper_addr), 32'(15'o30777));

    exp_q.push_back(12'o0050);               // R7 read IF
    step(1, 12'o6224, 0, 0);

    step(0, 12'o0000, 1, 0);                 // R4 transfer without pending
    fields("R4 no pending", 5, 3, 5, 0, 0);

    step(0, 12'o0000, 0, 1);                 // R5 interrupt entry
    fields("R5 entry", 0, 0, 5, 6'o53, 0);

    exp_q.push_back(12'o0053);               // R8 read SF
    step(1, 12'o6234, 0, 0);

    step(1, 12'o6244, 0, 0);                 // R9 restore
    fields("R9 restore", 0, 3, 5, 6'o53, 1);
    step(0, 12'o0000, 1, 0);
    fields("R9 then R4", 5, 3, 5, 6'o53, 0);

    // R11 ignored words
    step(1, 12'o6301, 0, 0);
    chk("R11 other device", 32'(df_field), 3);
    step(1, 12'o6273, 0, 0);
    chk("R11 function 011", 32'(df_field), 3);
    step(1, 12'o6254, 0, 0);
    chk("R11 sub-code 5 valid", 32'(ac_valid), 0);
    step(1, 12'o7271, 0, 0);
    chk("R11 other opcode", 32'(df_field), 3);
    step(0, 12'o6271, 0, 0);
    fields("R11 no strobe", 5, 3, 5, 6'o53, 0);

    step(1, 12'o6271, 0, 1);                 // R12 interrupt beats load
    fields("R12 int vs iot", 0, 0, 5, 6'o53, 0);
    step(1, 12'o6244, 0, 0);                 // restore: IB=5 DF=3
    step(1, 12'o6211, 1, 0);                 // R12 transfer beats load
    fields("R12 xfer vs iot", 5, 3, 5, 6'o53, 0);
    exp_q.push_back(12'o0000);
    step(1, 12'o6214, 0, 1);                 // R12 read dropped on interrupt
    chk("R12 dropped read", 32'(ac_valid), 0);
    void'(exp_q.pop_back());

    @(negedge clk);
    chk("R6/R7/R8 queue drained", 32'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule